// File: doc/BRIEF.md
# Dual-Port RAM with Collision Busy Arbitration

The block is a 1024-word by 8-bit memory with two ports that behave the same way, called left and right. Each port has an enable, a write strobe, an address, write data, registered read data and a busy output. Either port can read or write any location in any cycle. The only case that needs care is when both enabled ports point at the same word.

When both enabled ports address the same word, the block decides which port got there first. That port keeps full access. The other port receives a busy flag, and its writes are ignored while the flag is up. Arrival is judged once per clock cycle. A port counts as already present if it was enabled at the same address in the previous cycle. If both ports arrive in the same cycle, the left port wins.

Busy is a combinational function of the current inputs and a few registered bits. It rises in the cycle the collision starts, so the colliding write is blocked at that cycle's edge. It falls in the cycle the collision ends. If the losing port still holds its write strobe at that point, its write lands at the next edge.

Top module: `dpram_arb`

## Requirements
- R1: Reads are registered. `x_rdata` shows the word at `x_addr` one rising edge after a cycle with `x_en`=1 and `x_we`=0. In any other cycle it holds its value. When the addresses differ, busy stays low.
- R2: Two ports writing to different addresses in the same cycle both store their data.
- R3: Suppose the addresses already match and one port was enabled at that address in the previous cycle. If the other port becomes enabled now, the newly enabled port gets busy=1. This holds for both sides.
- R4: Suppose both ports are enabled and one port changes its address to the other port's address, while the other port kept its own address. The port that changed gets busy=1. This holds for both sides.
- R5: Suppose neither port was enabled at that address in the previous cycle and both arrive at the same address in one cycle. Then `r_busy`=1 and `l_busy`=0.
- R6: A write from a port whose busy is 1 does not change the memory.
- R7: Busy falls in the same cycle that an enable goes low or the addresses stop matching. If the losing port still holds its write, that write is stored at the next edge.
- R8: `l_busy` and `r_busy` are never 1 at the same time.
- R9: A port with busy=1 can still read. It returns the stored word, including a word written by the winning port in an earlier cycle.
- R10: After reset both busy outputs are 0 and both read-data outputs are 0.
- R11: Once a port is busy, it stays busy for as long as both ports remain enabled at the same, unchanged address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_en | input | 1 | Left port enable |
| l_we | input | 1 | Left write strobe (1 = write, 0 = read) |
| l_addr | input | 10 | Left word address |
| l_wdata | input | 8 | Left write data |
| l_rdata | output | 8 | Left registered read data |
| l_busy | output | 1 | Left port lost arbitration; its writes are blocked |
| r_en | input | 1 | Right port enable |
| r_we | input | 1 | Right write strobe (1 = write, 0 = read) |
| r_addr | input | 10 | Right word address |
| r_wdata | input | 8 | Right write data |
| r_rdata | output | 8 | Right registered read data |
| r_busy | output | 1 | Right port lost arbitration; its writes are blocked |

## Verification
The bench drives four kinds of arrival:
- **Enable arrival.** One port is parked at an address and the other port's enable rises on the same address. This tests whether the loser is chosen by when each enable rose.
- **Address arrival.** Both ports are already enabled and one of them moves onto the other's address. This tests whether the loser is chosen by which address changed.
- **Same-cycle arrival.** Both ports arrive together, which exposes the fixed tie-break.
- **Separate addresses.** Plain traffic on different addresses shows that busy never rises without a collision.

Each collision is ended in two ways, by dropping the winner's enable and by moving the winner's address. Both show that a held write lands only after busy falls. Read-back values tell a blocked write apart from a stored one.

// File: rtl/dpram_arb.sv
module dpram_arb #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_en,
  input  logic          l_we,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  output logic          l_busy,
  input  logic          r_en,
  input  logic          r_we,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata,
  output logic          r_busy
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  logic          l_en_q, r_en_q, hit_q, lose_l_q, lose_r_q;
  logic [AW-1:0] l_addr_q, r_addr_q;
  logic          hit, l_stay, r_stay, cont, left_late, l_wr, r_wr;

  assign hit       = l_en && r_en && (l_addr == r_addr);
  assign l_stay    = l_en_q && (l_addr_q == l_addr);
  assign r_stay    = r_en_q && (r_addr_q == r_addr);
  assign cont      = hit_q && (l_addr_q == l_addr);
  assign left_late = r_stay && !l_stay;

  assign l_busy = hit && (cont ? lose_l_q : left_late);
  assign r_busy = hit && (cont ? lose_r_q : !left_late);

  assign l_wr = l_en && l_we && !l_busy;
  assign r_wr = r_en && r_we && !r_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_en_q   <= 1'b0;
      r_en_q   <= 1'b0;
      l_addr_q <= '0;
      r_addr_q <= '0;
      hit_q    <= 1'b0;
      lose_l_q <= 1'b0;
      lose_r_q <= 1'b0;
    end else begin
      l_en_q   <= l_en;
      r_en_q   <= r_en;
      l_addr_q <= l_addr;
      r_addr_q <= r_addr;
      hit_q    <= hit;
      lose_l_q <= l_busy;
      lose_r_q <= r_busy;
    end
  end

  always_ff @(posedge clk) begin
    if (l_wr) mem[l_addr] <= l_wdata;
    if (r_wr) mem[r_addr] <= r_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_rdata <= '0;
      r_rdata <= '0;
    end else begin
      if (l_en && !l_we) l_rdata <= mem[l_addr];
      if (r_en && !r_we) r_rdata <= mem[r_addr];
    end
  end
endmodule

// File: rtl/dpram_arb_chk.sv
module dpram_arb_chk #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          l_en,
  input logic          l_we,
  input logic [AW-1:0] l_addr,
  input logic [DW-1:0] l_rdata,
  input logic          l_busy,
  input logic          r_en,
  input logic          r_we,
  input logic [AW-1:0] r_addr,
  input logic [DW-1:0] r_rdata,
  input logic          r_busy
);
  logic same;
  assign same = l_en && r_en && (l_addr == r_addr);

  a_r8_single_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_busy && r_busy));

  a_r3_right_late: assert property (@(posedge clk) disable iff (!rst_n)
    (same && $past(l_en) && ($past(l_addr) == l_addr) && !$past(r_en)) |-> (r_busy && !l_busy));

  a_r3_left_late: assert property (@(posedge clk) disable iff (!rst_n)
    (same && $past(r_en) && ($past(r_addr) == r_addr) && !$past(l_en)) |-> (l_busy && !r_busy));

  a_r5_left_wins_tie: assert property (@(posedge clk) disable iff (!rst_n)
    (same && !$past(l_en) && !$past(r_en)) |-> (r_busy && !l_busy));

  a_r11_left_holds: assert property (@(posedge clk) disable iff (!rst_n)
    l_busy |=> (l_busy || !(same && $stable(l_addr))));

  a_r11_right_holds: assert property (@(posedge clk) disable iff (!rst_n)
    r_busy |=> (r_busy || !(same && $stable(r_addr))));

  a_r1_left_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_en || l_we) |=> $stable(l_rdata));

  a_r1_right_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_en || r_we) |=> $stable(r_rdata));
endmodule

bind dpram_arb dpram_arb_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .l_en(l_en), .l_we(l_we), .l_addr(l_addr), .l_rdata(l_rdata), .l_busy(l_busy),
  .r_en(r_en), .r_we(r_we), .r_addr(r_addr), .r_rdata(r_rdata), .r_busy(r_busy)
);

// File: tb/dpram_arb_test.sv
module dpram_arb_test;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       l_en = 0, l_we = 0, r_en = 0, r_we = 0;
  logic [9:0] l_addr = '0, r_addr = '0;
  logic [7:0] l_wdata = '0, r_wdata = '0;
  logic [7:0] l_rdata, r_rdata;
  logic       l_busy, r_busy;
  int total = 0, bad = 0;

  always #(PERIOD/2) clk = ~clk;

  dpram_arb uut (
    .clk(clk), .rst_n(rst_n),
    .l_en(l_en), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .l_busy(l_busy),
    .r_en(r_en), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata),
    .r_rdata(r_rdata), .r_busy(r_busy)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic idle();
    l_en = 0; l_we = 0; r_en = 0; r_we = 0;
  endtask

  task automatic busy_is(input string req, input bit lb, input bit rb);
    settle();
    chk(req, "l_busy", int'(l_busy), int'(lb));
    chk(req, "r_busy", int'(r_busy), int'(rb));
  endtask

  task automatic poke(input logic [9:0] a, input logic [7:0] d);
    idle(); l_en = 1; l_we = 1; l_addr = a; l_wdata = d;
    step(); idle(); step();
  endtask

  task automatic peek_l(input string req, input logic [9:0] a, input logic [7:0] exp);
    idle(); l_en = 1; l_addr = a;
    step(); idle();
    chk(req, "l_rdata", int'(l_rdata), int'(exp));
    step();
  endtask

  task automatic peek_r(input string req, input logic [9:0] a, input logic [7:0] exp);
    idle(); r_en = 1; r_addr = a;
    step(); idle();
    chk(req, "r_rdata", int'(r_rdata), int'(exp));
    step();
  endtask

  task automatic t_reset();
    settle();
    chk("R10", "l_busy", int'(l_busy), 0);
    chk("R10", "r_busy", int'(r_busy), 0);
    chk("R10", "l_rdata", int'(l_rdata), 0);
    chk("R10", "r_rdata", int'(r_rdata), 0);
  endtask

  task automatic t_separate();
    l_en = 1; l_we = 1; l_addr = 10'd10; l_wdata = 8'hA5;
    r_en = 1; r_we = 1; r_addr = 10'd20; r_wdata = 8'h3C;
    busy_is("R2", 0, 0);
    step();
    l_we = 0; l_addr = 10'd20; r_we = 0; r_addr = 10'd10;
    busy_is("R1", 0, 0);
    step(); idle();
    chk("R2", "l_rdata", int'(l_rdata), 8'h3C);
    chk("R1", "r_rdata", int'(r_rdata), 8'hA5);
    step();
    chk("R1", "l_rdata hold", int'(l_rdata), 8'h3C);
  endtask

  task automatic t_enable_right_late();
    poke(10'd50, 8'h11);
    l_en = 1; l_we = 0; l_addr = 10'd50; r_addr = 10'd50;
    step();
    r_en = 1; r_we = 1; r_wdata = 8'hEE;
    busy_is("R3", 0, 1);
    step();
    busy_is("R11", 0, 1);
    chk("R6", "l_rdata", int'(l_rdata), 8'h11);
    step();
    chk("R6", "l_rdata", int'(l_rdata), 8'h11);
    l_en = 0;
    busy_is("R7", 0, 0);
    step(); idle();
    peek_l("R7", 10'd50, 8'hEE);
  endtask

  task automatic t_enable_left_late();
    poke(10'd60, 8'h22);
    r_en = 1; r_we = 0; r_addr = 10'd60; l_addr = 10'd60;
    step();
    l_en = 1; l_we = 1; l_wdata = 8'h77;
    busy_is("R3", 1, 0);
    step();
    chk("R6", "r_rdata", int'(r_rdata), 8'h22);
    busy_is("R11", 1, 0);
    step();
    chk("R6", "r_rdata", int'(r_rdata), 8'h22);
    r_addr = 10'd61;
    busy_is("R7", 0, 0);
    step(); idle();
    peek_r("R7", 10'd60, 8'h77);
  endtask

  task automatic t_address_late();
    poke(10'd100, 8'h44);
    l_en = 1; l_we = 0; l_addr = 10'd100;
    r_en = 1; r_we = 0; r_addr = 10'd101;
    step();
    r_addr = 10'd100; r_we = 1; r_wdata = 8'h99;
    busy_is("R4", 0, 1);
    step(); idle(); step();
    peek_l("R6", 10'd100, 8'h44);
    r_en = 1; r_we = 0; r_addr = 10'd200;
    l_en = 1; l_we = 0; l_addr = 10'd201;
    step();
    l_addr = 10'd200;
    r_we = 1; r_wdata = 8'h5A;
    busy_is("R4", 1, 0);
    step();
    r_we = 0;
    busy_is("R11", 1, 0);
    step();
    chk("R9", "l_rdata", int'(l_rdata), 8'h5A);
    idle(); step();
  endtask

  task automatic t_tie();
    l_en = 1; l_we = 1; l_addr = 10'd300; l_wdata = 8'h12;
    r_en = 1; r_we = 1; r_addr = 10'd300; r_wdata = 8'h34;
    busy_is("R5", 0, 1);
    step(); idle(); step();
    peek_r("R5", 10'd300, 8'h12);
  endtask

  initial begin
    #(PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step();
    t_reset();
    step();
    rst_n = 1;
    step();
    t_separate();
    t_enable_right_late();
    t_enable_left_late();
    t_address_late();
    t_tie();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule